// File: doc/BRIEF.md
# Programmable FIFO Status Flag Generator

This block derives the status flags of a dual-clock FIFO from the two word pointers. The write pointer lives in the write clock domain and the read pointer in the read clock domain. Each pointer reaches the other domain as a Gray code through a two-flop synchronizer, so each domain has its own view of the word count. The block produces five active-low style flags: full, almost-full, half-full, almost-empty and empty. The almost thresholds come from an empty offset `n` and a full offset `m`, both supplied as inputs. Pointer generation and the storage array are outside the block. Both pointers are free-running binary word counters that advance by at most one per edge of their own clock.

Two options are captured while master reset is held, and changes to them later have no effect. The first selects standard or first-word-fall-through (FWFT) counting. In FWFT mode the full pin becomes an input-ready indication and the empty pin an output-ready indication, both high when the FIFO cannot accept or supply a word. Every threshold also moves up by one word, because the output stage holds one extra word. The second option selects the timing of the almost flags. In synchronous timing, almost-full is computed and updated only in the write domain, and almost-empty only in the read domain. In asynchronous timing, almost-full is asserted by a write clock edge and released by a read clock edge. Almost-empty is asserted by a read clock edge and released by a write clock edge.

Master reset (`mrst`) is synchronous to both clocks and must be held for several edges of each. Below, D is the depth, c is the word count (write pointer minus read pointer), and f is 1 in FWFT mode and 0 in standard mode.

Top module: `fifo_flag_gen`

## Requirements
- R1: In standard mode `rempty_flag` is 0 when c = 0 and 1 otherwise.
- R2: `almost_empty_n` is 0 when c <= n + f and 1 otherwise.
- R3: `half_full_n` is 0 when c >= D/2 + 1 + f and 1 otherwise.
- R4: `almost_full_n` is 0 when c >= D - m + f and 1 otherwise.
- R5: In standard mode `wfull_flag` is 0 when c = D and 1 otherwise.
- R6: In FWFT mode `wfull_flag` is 1 (not ready) when c >= D + 1 and 0 otherwise, and `rempty_flag` is 1 (not ready) when c = 0 and 0 otherwise.
- R7: With synchronous timing (`sync_flag_sel` = 1 at reset), `almost_full_n` changes only on a write clock edge and `almost_empty_n` only on a read clock edge. A read with the write clock stopped leaves `almost_full_n` asserted, and a write with the read clock stopped leaves `almost_empty_n` asserted.
- R8: With asynchronous timing (`sync_flag_sel` = 0 at reset), a read that takes c below the almost-full threshold releases `almost_full_n` with only the read clock running. A write that takes c above the almost-empty threshold releases `almost_empty_n` with only the write clock running.
- R9: While `mrst` is high, empty (standard) or output-not-ready (FWFT) and almost-empty are asserted, and full, almost-full and half-full are released. So `wfull_flag` = 1 (standard) or 0 (FWFT), `rempty_flag` = 0 (standard) or 1 (FWFT), `half_full_n` = 1, `almost_full_n` = 1 and `almost_empty_n` = 0.
- R10: `fwft_sel` and `sync_flag_sel` are sampled only while `mrst` is high. Changing them after reset changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous to both clocks |
| fwft_sel | input | 1 | 1 = FWFT counting, sampled during reset |
| sync_flag_sel | input | 1 | 1 = synchronous almost-flag timing, sampled during reset |
| wr_ptr | input | PTR_W | Binary write pointer, write domain |
| rd_ptr | input | PTR_W | Binary read pointer, read domain |
| empty_ofs | input | OFS_W | Almost-empty offset n (0 to D-1) |
| full_ofs | input | OFS_W | Almost-full offset m (0 to D-1) |
| wfull_flag | output | 1 | Full (active low, standard) or input-not-ready (high, FWFT) |
| rempty_flag | output | 1 | Empty (active low, standard) or output-not-ready (high, FWFT) |
| half_full_n | output | 1 | Half-full, active low, write domain |
| almost_full_n | output | 1 | Almost-full, active low |
| almost_empty_n | output | 1 | Almost-empty, active low |

## Verification
The embedded assertions check on every edge that the flags stay consistent with each other. A full indication in standard mode must come with almost-full and half-full. An empty indication must come with the read domain's almost-empty view. Each domain must come out of reset holding the reset flag values. The level of every flag at each word count, the one-word shift in FWFT mode, and the insensitivity to mode pins after reset need the bench's sweeps, which drive the count up to its limit and back and then compare the settled flags. The difference between synchronous and asynchronous almost-flag timing shows only in the bench's stopped-clock scenarios.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

    // Write-domain state
    typedef struct packed {
        logic cfg_fwft;
        logic cfg_sync;
        logic full_flag;
        logic hf_n;
        logic af_view;
        logic ae_view;
        logic af_tog;
        logic ae_tog;
    } wside_t;

    // Read-domain state
    typedef struct packed {
        logic cfg_fwft;
        logic cfg_sync;
        logic ef_flag;
        logic ae_view;
        logic af_view;
        logic ae_tog;
        logic af_tog;
    } rside_t;

endpackage

// File: rtl/ffg_gray_sync.sv
module ffg_gray_sync #(
    parameter int W = 6
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] gray_d, gray_q;
    logic [W-1:0] s1_q, s2_q;
    logic [W-1:0] bin_d;

    // Source side: register the Gray form so only one bit moves per step
    always_comb begin
        gray_d = src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge src_clk) begin
        if (src_rst) gray_q <= '0;
        else         gray_q <= gray_d;
    end

    // Destination side: two-flop synchronizer
    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_q;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        bin_d[W-1] = s2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_d[i] = bin_d[i+1] ^ s2_q[i];
        end
    end

    assign dst_bin = bin_d;

endmodule

// File: rtl/ffg_wside.sv
module ffg_wside
    import ffg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = 6,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwft_pin,
    input  logic             sync_pin,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr_s,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    input  logic             af_on,
    input  logic             ae_rel,
    output logic             full_flag,
    output logic             hf_n,
    output logic             af_view,
    output logic             af_tog,
    output logic             ae_tog,
    output logic             cfg_sync
);
    localparam int CW = PTR_W + 1;

    wside_t          q, d;
    logic [PTR_W-1:0] diff;
    logic [CW-1:0]    cnt, f, thr_full, thr_half, thr_af, thr_ae;

    always_comb begin
        diff     = wptr - rptr_s;
        cnt      = {1'b0, diff};
        f        = CW'(q.cfg_fwft);
        thr_full = CW'(DEPTH) + f;
        thr_half = CW'(DEPTH / 2 + 1) + f;
        thr_af   = CW'(DEPTH) - CW'(af_ofs) + f;
        thr_ae   = CW'(ae_ofs) + f;

        d = q;
        if (rst) begin
            d.cfg_fwft  = fwft_pin;
            d.cfg_sync  = sync_pin;
            d.full_flag = ~fwft_pin;
            d.hf_n      = 1'b1;
            d.af_view   = 1'b0;
            d.ae_view   = 1'b1;
            d.af_tog    = 1'b0;
            d.ae_tog    = 1'b0;
        end else begin
            d.full_flag = q.cfg_fwft ? (cnt >= thr_full) : ~(cnt >= thr_full);
            d.hf_n      = ~(cnt >= thr_half);
            d.af_view   = (cnt >= thr_af);
            d.ae_view   = (cnt <= thr_ae);
            // Write edge crossing into almost-full sets the shared flag
            if (d.af_view && !q.af_view && !af_on) d.af_tog = ~q.af_tog;
            // Write edge leaving almost-empty releases the shared flag
            if (!d.ae_view && q.ae_view && !ae_rel) d.ae_tog = ~q.ae_tog;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign full_flag = q.full_flag;
    assign hf_n      = q.hf_n;
    assign af_view   = q.af_view;
    assign af_tog    = q.af_tog;
    assign ae_tog    = q.ae_tog;
    assign cfg_sync  = q.cfg_sync;

    // R5: a full indication implies almost-full and half-full
    assert_full_implies_af_R5: assert property (@(posedge clk) disable iff (rst)
        (!q.cfg_fwft && !q.full_flag) |-> (q.af_view && !q.hf_n));

    // R9: write domain leaves reset with released full-side flags
    assert_wreset_values_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q.hf_n && !q.af_view && q.ae_view && (q.full_flag == ~q.cfg_fwft)));

endmodule

// File: rtl/ffg_rside.sv
module ffg_rside
    import ffg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = 6,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwft_pin,
    input  logic             sync_pin,
    input  logic [PTR_W-1:0] wptr_s,
    input  logic [PTR_W-1:0] rptr,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    input  logic             af_on,
    input  logic             ae_rel,
    output logic             ef_flag,
    output logic             ae_view,
    output logic             ae_tog,
    output logic             af_tog,
    output logic             cfg_sync
);
    localparam int CW = PTR_W + 1;

    rside_t          q, d;
    logic [PTR_W-1:0] diff;
    logic [CW-1:0]    cnt, f, thr_af, thr_ae;

    always_comb begin
        diff   = wptr_s - rptr;
        cnt    = {1'b0, diff};
        f      = CW'(q.cfg_fwft);
        thr_af = CW'(DEPTH) - CW'(af_ofs) + f;
        thr_ae = CW'(ae_ofs) + f;

        d = q;
        if (rst) begin
            d.cfg_fwft = fwft_pin;
            d.cfg_sync = sync_pin;
            d.ef_flag  = fwft_pin;
            d.ae_view  = 1'b1;
            d.af_view  = 1'b0;
            d.ae_tog   = 1'b0;
            d.af_tog   = 1'b0;
        end else begin
            d.ef_flag = q.cfg_fwft ? (cnt == '0) : (cnt != '0);
            d.ae_view = (cnt <= thr_ae);
            d.af_view = (cnt >= thr_af);
            // Read edge crossing into almost-empty asserts the shared flag
            if (d.ae_view && !q.ae_view && ae_rel) d.ae_tog = ~q.ae_tog;
            // Read edge leaving almost-full releases the shared flag
            if (!d.af_view && q.af_view && af_on) d.af_tog = ~q.af_tog;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign ef_flag  = q.ef_flag;
    assign ae_view  = q.ae_view;
    assign ae_tog   = q.ae_tog;
    assign af_tog   = q.af_tog;
    assign cfg_sync = q.cfg_sync;

    // R1/R2: an empty indication implies the almost-empty view
    assert_empty_implies_ae_R2: assert property (@(posedge clk) disable iff (rst)
        (q.ef_flag == q.cfg_fwft) |-> q.ae_view);

    // R9: read domain leaves reset with empty and almost-empty asserted
    assert_rreset_values_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q.ae_view && !q.af_view && (q.ef_flag == q.cfg_fwft)));

endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH) + 2,
    parameter int OFS_W = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mrst,
    input  logic             fwft_sel,
    input  logic             sync_flag_sel,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic             wfull_flag,
    output logic             rempty_flag,
    output logic             half_full_n,
    output logic             almost_full_n,
    output logic             almost_empty_n
);
    logic [PTR_W-1:0] rptr_in_w, wptr_in_r;
    logic w_af_view, w_af_tog, w_ae_tog, w_cfg_sync;
    logic r_ae_view, r_ae_tog, r_af_tog, r_cfg_sync;
    logic af_on, ae_rel;

    // Dual-clock set/release flags built from one toggle per domain
    assign af_on  = w_af_tog ^ r_af_tog;
    assign ae_rel = w_ae_tog ^ r_ae_tog;

    ffg_gray_sync #(.W(PTR_W)) u_w2r (
        .src_clk (wr_clk),
        .src_rst (mrst),
        .src_bin (wr_ptr),
        .dst_clk (rd_clk),
        .dst_rst (mrst),
        .dst_bin (wptr_in_r)
    );

    ffg_gray_sync #(.W(PTR_W)) u_r2w (
        .src_clk (rd_clk),
        .src_rst (mrst),
        .src_bin (rd_ptr),
        .dst_clk (wr_clk),
        .dst_rst (mrst),
        .dst_bin (rptr_in_w)
    );

    ffg_wside #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OFS_W(OFS_W)) u_wside (
        .clk       (wr_clk),
        .rst       (mrst),
        .fwft_pin  (fwft_sel),
        .sync_pin  (sync_flag_sel),
        .wptr      (wr_ptr),
        .rptr_s    (rptr_in_w),
        .ae_ofs    (empty_ofs),
        .af_ofs    (full_ofs),
        .af_on     (af_on),
        .ae_rel    (ae_rel),
        .full_flag (wfull_flag),
        .hf_n      (half_full_n),
        .af_view   (w_af_view),
        .af_tog    (w_af_tog),
        .ae_tog    (w_ae_tog),
        .cfg_sync  (w_cfg_sync)
    );

    ffg_rside #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OFS_W(OFS_W)) u_rside (
        .clk      (rd_clk),
        .rst      (mrst),
        .fwft_pin (fwft_sel),
        .sync_pin (sync_flag_sel),
        .wptr_s   (wptr_in_r),
        .rptr     (rd_ptr),
        .ae_ofs   (empty_ofs),
        .af_ofs   (full_ofs),
        .af_on    (af_on),
        .ae_rel   (ae_rel),
        .ef_flag  (rempty_flag),
        .ae_view  (r_ae_view),
        .ae_tog   (r_ae_tog),
        .af_tog   (r_af_tog),
        .cfg_sync (r_cfg_sync)
    );

    // R7/R8: timing option picks single-domain or dual-clock almost flags
    assign almost_full_n  = w_cfg_sync ? ~w_af_view : ~af_on;
    assign almost_empty_n = r_cfg_sync ? ~r_ae_view : ae_rel;

endmodule

// File: tb/fifo_flag_gen_test.sv
module fifo_flag_gen_test;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int D  = 16;
    localparam int PW = $clog2(D) + 2;
    localparam int OW = $clog2(D);

    logic wr_clk = 0, rd_clk = 0;
    logic wclk_en = 1, rclk_en = 1;
    logic mrst = 1, fwft_sel = 0, sync_flag_sel = 0;
    logic [PW-1:0] wr_ptr = '0, rd_ptr = '0;
    logic [OW-1:0] empty_ofs = '0, full_ofs = '0;
    logic wfull_flag, rempty_flag, half_full_n, almost_full_n, almost_empty_n;

    int tests = 0, fails = 0;
    int cf, cs, cn, cm;
    bit done = 0;

    always #(CLK_PERIOD/2)  if (wclk_en) wr_clk = ~wr_clk;
    always #(RCLK_PERIOD/2) if (rclk_en) rd_clk = ~rd_clk;

    fifo_flag_gen #(.DEPTH(D)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst),
        .fwft_sel(fwft_sel), .sync_flag_sel(sync_flag_sel),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .wfull_flag(wfull_flag), .rempty_flag(rempty_flag),
        .half_full_n(half_full_n), .almost_full_n(almost_full_n),
        .almost_empty_n(almost_empty_n)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b (fwft=%0d sync=%0d n=%0d m=%0d)",
                     tag, what, act, exp, cf, cs, cn, cm);
        end
    endtask

    task automatic check_level(input int c);
        string tm;
        tm = cs ? "R7" : "R8";
        chk(wfull_flag, cf ? logic'(c >= D + 1) : logic'(!(c >= D)), cf ? "R6" : "R5",
            $sformatf("full pin at %0d words", c));
        chk(rempty_flag, cf ? logic'(c == 0) : logic'(c != 0), cf ? "R6" : "R1",
            $sformatf("empty pin at %0d words", c));
        chk(half_full_n, logic'(!(c >= D/2 + 1 + cf)), "R3",
            $sformatf("half-full at %0d words", c));
        chk(almost_full_n, logic'(!(c >= D - cm + cf)), "R4",
            $sformatf("almost-full at %0d words (%s timing)", c, tm));
        chk(almost_empty_n, logic'(!(c <= cn + cf)), "R2",
            $sformatf("almost-empty at %0d words (%s timing)", c, tm));
    endtask

    task automatic settle();
        repeat (10) @(posedge rd_clk);
        @(negedge wr_clk);
    endtask

    task automatic write_one();
        @(negedge wr_clk) wr_ptr <= wr_ptr + 1'b1;
    endtask

    task automatic read_one();
        @(negedge rd_clk) rd_ptr <= rd_ptr + 1'b1;
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        mrst = 1;
        fwft_sel = cf[0];
        sync_flag_sel = cs[0];
        wr_ptr = '0;
        rd_ptr = '0;
        empty_ofs = OW'(cn);
        full_ofs = OW'(cm);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        // R9: flag values while reset is held
        chk(wfull_flag, cf ? 1'b0 : 1'b1, "R9", "full pin during reset");
        chk(rempty_flag, cf ? 1'b1 : 1'b0, "R9", "empty pin during reset");
        chk(half_full_n, 1'b1, "R9", "half-full during reset");
        chk(almost_full_n, 1'b1, "R9", "almost-full during reset");
        chk(almost_empty_n, 1'b0, "R9", "almost-empty during reset");
        mrst = 0;
        // R10: invert mode pins after reset; flags must follow the sampled values
        fwft_sel = ~cf[0];
        sync_flag_sel = ~cs[0];
        settle();
        chk(rempty_flag, cf ? 1'b1 : 1'b0, "R10", "empty pin after mode pins flipped");
        chk(wfull_flag, cf ? 1'b0 : 1'b1, "R10", "full pin after mode pins flipped");
    endtask

    task automatic timing_checks();
        int c;
        c = 0;
        // Fill to the almost-full threshold
        while (c < D - cm + cf) begin write_one(); c++; end
        settle();
        chk(almost_full_n, 1'b0, cs ? "R7" : "R8", "almost-full at threshold before stop");
        // Stop the write clock and read one word
        @(negedge wr_clk) wclk_en = 0;
        read_one(); c--;
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
        chk(almost_full_n, cs ? 1'b0 : 1'b1, cs ? "R7" : "R8",
            "almost-full after read with write clock stopped");
        wclk_en = 1;
        settle();
        chk(almost_full_n, 1'b1, cs ? "R7" : "R8", "almost-full after write clock restarts");
        // Drain to the almost-empty threshold
        while (c > cn + cf) begin read_one(); c--; end
        settle();
        chk(almost_empty_n, 1'b0, cs ? "R7" : "R8", "almost-empty at threshold before stop");
        @(negedge rd_clk) rclk_en = 0;
        write_one(); c++;
        repeat (6) @(posedge wr_clk);
        @(negedge wr_clk);
        chk(almost_empty_n, cs ? 1'b0 : 1'b1, cs ? "R7" : "R8",
            "almost-empty after write with read clock stopped");
        rclk_en = 1;
        settle();
        chk(almost_empty_n, 1'b1, cs ? "R7" : "R8", "almost-empty after read clock restarts");
    endtask

    initial begin
        int ns [3] = '{3, 0, 15};
        int ms [3] = '{5, 15, 0};
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 3; p++) begin
                    cf = f; cs = s; cn = ns[p]; cm = ms[p];
                    do_reset();
                    check_level(0);
                    for (int c = 1; c <= D + f; c++) begin
                        write_one();
                        settle();
                        check_level(c);
                    end
                    for (int c = D + f - 1; c >= 0; c--) begin
                        read_one();
                        settle();
                        check_level(c);
                    end
                    if (p == 0) timing_checks();
                end
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R9: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule